// File: doc/BRIEF.md
# Four-Line Multiline Segment Level Decoder

This block selects the drive level for every column of a passive matrix display that is addressed four rows at a time. For each column it takes the display bits of four vertically adjacent lines, n through n+3, and compares them with one of four orthogonal row sign patterns. The result is one of five levels: two of each polarity and a centre level. The agreement between the data and the chosen pattern sets the level's magnitude. An AC polarity input mirrors the level about the centre, so the panel sees no net DC over time.

Two global controls act on the whole display. One inverts the sense of every dot before decoding. The other blanks the display, which forces every column to the centre level. The decoded codes for all columns are captured together on the falling edge of the line clock. A change in pattern, polarity or data therefore reaches the outputs at the next falling edge. The width is set by the column count parameter. The analog output stage and the display memory sit outside the block.

Top module: `mline_seg_decoder`

## Requirements
- R1: Each column outputs a 3-bit level code: 0 = -V3, 1 = -V2, 2 = VC, 3 = +V2, 4 = +V3. No other code ever appears.
- R2: The pattern selector (pat_f2, pat_f1) marks one line as negative and leaves the other three positive. 11 marks line n+1, 10 marks line n+2, 01 marks line n, and 00 marks line n+3.
- R3: With polarity low, each line adds +1 to a score when its bit matches its sign (0 on a positive line, 1 on the negative line) and -1 otherwise. The code is 2 + score/2, so four agreements give +V3 and four mismatches give -V3.
- R4: With polarity high, the code is mirrored about VC: it is 4 minus the code that the same inputs give with polarity low.
- R5: With the invert control high, all four data bits of every column are complemented before scoring. The result equals the result for the complemented data with invert low.
- R6: With the blank control high, every column takes code 2 (VC) at that falling edge, whatever the data, pattern, polarity and invert inputs are.
- R7: Outputs change only on the falling edge of line_clk. An input change made between two falling edges shows on the outputs after the next falling edge, and not before it.
- R8: An active-low rst_n sets every column to code 2 (VC) at once, without waiting for a clock edge.
- R9: Reference points, with bits written in line order n..n+3 and polarity low. Pattern 11 gives 0000 → 3, 0100 → 4, 1111 → 1 and 1011 → 0. Pattern 00 gives 0001 → 4 and 1110 → 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line clock; outputs update on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row0 | input | COLS | Display bits of line n, one per column |
| row1 | input | COLS | Display bits of line n+1 |
| row2 | input | COLS | Display bits of line n+2 |
| row3 | input | COLS | Display bits of line n+3 |
| pat_f2 | input | 1 | Drive pattern selector, upper bit |
| pat_f1 | input | 1 | Drive pattern selector, lower bit |
| fr | input | 1 | AC polarity; high mirrors all levels |
| invert | input | 1 | Whole-display dot inversion |
| blank | input | 1 | Display off; forces VC everywhere |
| level | output | 3*COLS | Level code per column, column c at bits 3c+2..3c |

## Verification
The bench runs all sixteen four-bit data values under every pattern, both polarities and both invert settings. Each column is given a different offset of the data value, so a swapped column or line shows up as a mismatch. The expected code is found by counting mismatches against a target word, which separates errors in the selector mapping, the score sign and the polarity mirror. Separate checks cover the six reference entries, blanking under non-centre data, the one-edge delay of a polarity change, and the asynchronous reset.

// File: rtl/mline_seg_decoder.sv
module mline_seg_decoder #(
  parameter int COLS = 160
) (
  input  logic                  line_clk,
  input  logic                  rst_n,
  input  logic [COLS-1:0]       row0,
  input  logic [COLS-1:0]       row1,
  input  logic [COLS-1:0]       row2,
  input  logic [COLS-1:0]       row3,
  input  logic                  pat_f2,
  input  logic                  pat_f1,
  input  logic                  fr,
  input  logic                  invert,
  input  logic                  blank,
  output logic [3*COLS-1:0]     level
);

  localparam logic [2:0] LVL_VC = 3'd2;
  localparam logic [2:0] LVL_MAX = 3'd4;
  localparam int LW = 3*COLS;
  localparam logic [LW-1:0] ALL_VC = {COLS{LVL_VC}};

  logic [3:0] neg_line;

  always_comb begin
    unique case ({pat_f2, pat_f1})
      2'b11:   neg_line = 4'b0010;
      2'b10:   neg_line = 4'b0100;
      2'b01:   neg_line = 4'b0001;
      default: neg_line = 4'b1000;
    endcase
  end

  genvar c;
  generate
    for (c = 0; c < COLS; c++) begin : g_col
      logic [3:0] dots;
      logic [2:0] miss;
      logic [2:0] nxt;

      assign dots = {row3[c], row2[c], row1[c], row0[c]} ^ {4{invert}};
      assign miss = 3'(dots[0] ^ neg_line[0]) + 3'(dots[1] ^ neg_line[1])
                  + 3'(dots[2] ^ neg_line[2]) + 3'(dots[3] ^ neg_line[3]);
      assign nxt  = fr ? miss : LVL_MAX - miss;

      always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n)     level[3*c +: 3] <= LVL_VC;
        else if (blank) level[3*c +: 3] <= LVL_VC;
        else            level[3*c +: 3] <= nxt;
      end

      assert_code_range_R1: assert property (@(negedge line_clk) disable iff (!rst_n)
        level[3*c +: 3] <= LVL_MAX);
    end
  endgenerate

  logic [1:0] warm;
  always_ff @(negedge line_clk or negedge rst_n) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic [4*COLS-1:0] rows_all;
  assign rows_all = {row3, row2, row1, row0};

  assert_blank_vc_R6: assert property (@(negedge line_clk) disable iff (!rst_n)
    (warm != 2'd0 && $past(blank)) |-> level == ALL_VC);

  assert_fr_mirror_R4: assert property (@(negedge line_clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(fr) != $past(fr, 2) && !$past(blank) && !$past(blank, 2)
     && $past(rows_all) == $past(rows_all, 2) && $past(invert) == $past(invert, 2)
     && $past({pat_f2, pat_f1}) == $past({pat_f2, pat_f1}, 2))
    |-> level[2:0] == LVL_MAX - $past(level[2:0]));

  assert_invert_complement_R5: assert property (@(negedge line_clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(invert) != $past(invert, 2) && !$past(blank) && !$past(blank, 2)
     && $past(rows_all) == ~$past(rows_all, 2) && $past(fr) == $past(fr, 2)
     && $past({pat_f2, pat_f1}) == $past({pat_f2, pat_f1}, 2))
    |-> $stable(level));

  assert_hold_R7: assert property (@(negedge line_clk) disable iff (!rst_n)
    (warm == 2'd3 && $past({rows_all, pat_f2, pat_f1, fr, invert, blank})
       == $past({rows_all, pat_f2, pat_f1, fr, invert, blank}, 2))
    |-> $stable(level));

endmodule

// File: tb/mline_seg_decoder_test.sv
module mline_seg_decoder_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] row0 = '0, row1 = '0, row2 = '0, row3 = '0;
  logic f2 = 1'b0, f1 = 1'b0, fr = 1'b0, inv = 1'b0, blank = 1'b0;
  logic [3*N-1:0] level;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mline_seg_decoder #(.COLS(N)) uut (
    .line_clk(clk), .rst_n(rst_n), .row0(row0), .row1(row1), .row2(row2), .row3(row3),
    .pat_f2(f2), .pat_f1(f1), .fr(fr), .invert(inv), .blank(blank), .level(level)
  );

  function automatic logic [2:0] expect_code(input logic [1:0] p, input logic fpol,
                                             input logic iv, input logic bl, input logic [3:0] d);
    logic [3:0] tgt;
    int m;
    if (bl) return 3'd2;
    case (p)
      2'b11: tgt = 4'b0010;
      2'b10: tgt = 4'b0100;
      2'b01: tgt = 4'b0001;
      default: tgt = 4'b1000;
    endcase
    m = $countones((d ^ {4{iv}}) ^ tgt);
    return fpol ? 3'(m) : 3'(4 - m);
  endfunction

  logic [15:0] cur_d;
  logic [1:0]  cur_p;
  logic        cur_fr, cur_iv, cur_bl;

  task automatic drive(input logic [1:0] p, input logic fpol, input logic iv,
                       input logic bl, input logic [15:0] dall);
    for (int c = 0; c < N; c++) begin
      row0[c] = dall[4*c];
      row1[c] = dall[4*c+1];
      row2[c] = dall[4*c+2];
      row3[c] = dall[4*c+3];
    end
    {f2, f1} = p; fr = fpol; inv = iv; blank = bl;
    cur_d = dall; cur_p = p; cur_fr = fpol; cur_iv = iv; cur_bl = bl;
  endtask

  task automatic check_col(input string req, input int c, input logic [2:0] exp);
    total++;
    if (level[3*c +: 3] !== exp) begin
      bad++;
      $display("FAIL %s col=%0d actual=%0d expected=%0d", req, c, level[3*c +: 3], exp);
    end
  endtask

  task automatic check_cur(input string req);
    for (int c = 0; c < N; c++)
      check_col(req, c, expect_code(cur_p, cur_fr, cur_iv, cur_bl, cur_d[4*c +: 4]));
  endtask

  task automatic step(input logic [1:0] p, input logic fpol, input logic iv,
                      input logic bl, input logic [15:0] dall, input string req);
    @(posedge clk);
    drive(p, fpol, iv, bl, dall);
    @(posedge clk);
    check_cur(req);
  endtask

  task automatic spot(input logic [1:0] p, input logic [3:0] d, input logic [2:0] exp);
    @(posedge clk);
    drive(p, 1'b0, 1'b0, 1'b0, {4{d}});
    @(posedge clk);
    check_col("R9", 0, exp);
    check_col("R9", 3, exp);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(2'b11, 1'b0, 1'b0, 1'b0, 16'h2D0F);
    repeat (3) @(posedge clk);
    for (int c = 0; c < N; c++) check_col("R8 reset", c, 3'd2);
    rst_n = 1'b1;

    // R9 reference entries, bits listed n..n+3 (d[0] = line n)
    spot(2'b11, 4'b0000, 3'd3);
    spot(2'b11, 4'b0010, 3'd4);
    spot(2'b11, 4'b1111, 3'd1);
    spot(2'b11, 4'b1101, 3'd0);
    spot(2'b00, 4'b1000, 3'd4);
    spot(2'b00, 4'b0111, 3'd0);

    // R1 R2 R3 R4 R5 exhaustive sweep
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 2; f++)
        for (int iv = 0; iv < 2; iv++)
          for (int v = 0; v < 16; v++) begin
            logic [15:0] dall;
            for (int c = 0; c < N; c++) dall[4*c +: 4] = 4'((v + 5*c) % 16);
            step(2'(p), 1'(f), 1'(iv), 1'b0, dall, "R1 R2 R3 R4 R5 sweep");
          end

    // R6 blank over data that would give non-centre codes
    step(2'b11, 1'b0, 1'b0, 1'b1, 16'h2F2D, "R6 blank");
    step(2'b00, 1'b1, 1'b1, 1'b1, 16'h8787, "R6 blank");
    step(2'b00, 1'b1, 1'b0, 1'b0, 16'h8787, "R6 release");

    // R7 polarity change between edges appears only after next falling edge
    step(2'b11, 1'b0, 1'b0, 1'b0, 16'h2222, "R7 before");
    drive(2'b11, 1'b1, 1'b0, 1'b0, 16'h2222);
    #2;
    for (int c = 0; c < N; c++) check_col("R7 hold", c, 3'd4);
    @(posedge clk);
    for (int c = 0; c < N; c++) check_col("R7 update", c, 3'd0);

    // R8 asynchronous reset mid-run
    @(posedge clk);
    rst_n = 1'b0;
    #1;
    for (int c = 0; c < N; c++) check_col("R8 async", c, 3'd2);
    @(posedge clk);
    rst_n = 1'b1;
    step(2'b01, 1'b0, 1'b0, 1'b0, 16'h1111, "R3 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule